// File: doc/BRIEF.md
# Serial Stereo Audio Receiver with Bit-Clock Mode Detection

This block takes stereo audio in on a three-wire serial link: a bit clock, a word-select (channel) clock and a data line. All three arrive as raw pins. The block oversamples them in the master-clock domain through two-flop synchronizers and finds their edges there. Nothing in the block runs on the serial clocks.

When the external bit clock is toggling, the block samples data on its rising edges. When the external bit clock is quiet, the block makes its own bit strobe by dividing the master clock. The divisor comes from the master-to-frame ratio code that a separate ratio detector supplies. The block switches between the two sources on its own and raises a one-cycle pulse on every switch. Downstream muting logic treats that pulse as a clock fault.

Words arrive MSB first in two's complement, in the usual one-bit-delayed stereo framing. A word is packed left-justified into a 24-bit sample: short words are padded with zeros and long words are cut off. The left and right samples are presented together with a single valid strobe once each frame is complete.

Top module: `serrx_top`

## Requirements
- R1: Data is sampled on each rising edge of the active bit clock. The first rising edge after a word-select transition carries the final bit of the word that just ended. The second rising edge carries the MSB of the new word. Further bits follow MSB first, and the word is two's complement.
- R2: A word sent while word-select is low belongs to the left channel. A word sent while it is high belongs to the right channel. Both samples update together with a one-cycle `sampleValid`, after the right word closes at the first bit-clock rise following the next high-to-low word-select edge.
- R3: A word shorter than 24 bits lands in bits 23 downward of its sample, and the unused low bits read zero.
- R4: Bits after the 24th of a word are ignored and do not change the sample.
- R5: Any rising edge on `sclkIn` while the block is in internal mode switches it to external mode, and `extClkMode` reads 1.
- R6: In external mode, if two consecutive rising edges of word-select pass with no external bit-clock rise between them, the block returns to internal mode and `extClkMode` reads 0.
- R7: Every switch between modes raises `modeChange` for exactly one cycle, at the same time as `extClkMode` changes. With the default (continuous) clock timing, no word pair that had started before the switch is presented.
- R8: The internal bit strobe uses a divisor N of 8 for ratio codes 0 (256) and 1 (384), and 16 for code 2 (512). The strobe fires N/2 cycles after the synchronized word-select edge and then every N cycles, giving 16, 24 and 16 bits per word. Code 3 (invalid) gives no internal strobes and so no samples.
- R9: After reset both samples are zero, `sampleValid`, `extClkMode` and `modeChange` are 0, and the sample outputs hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all logic runs on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | Raw external bit clock |
| lrclkIn | input | 1 | Raw word-select clock (low = left, high = right) |
| sdataIn | input | 1 | Raw serial data |
| ratioCode | input | 2 | Master-to-frame ratio: 0 = 256, 1 = 384, 2 = 512, 3 = invalid |
| leftSample | output | WORD_W | Left sample, left-justified |
| rightSample | output | WORD_W | Right sample, left-justified |
| sampleValid | output | 1 | One-cycle strobe when a new sample pair is presented |
| extClkMode | output | 1 | 1 while the external bit clock is in use |
| modeChange | output | 1 | One-cycle pulse on each mode switch |

## Verification
The assertions watch, on every cycle, the relations that hold locally. A mode pulse must match a flip of the mode flag. An external edge seen in internal mode must move the block to external mode. An invalid ratio must suppress internal strobes. The valid strobe must never last more than one cycle. The samples may change only together with a strobe. A full word must stay frozen against extra bits. Only the bench scenarios can show that whole words come out right: bit order, channel steering, padding and truncation at each ratio and in external mode. The same holds for the timeout back to internal mode after a quiet frame, and for dropping the interrupted pair.

// File: rtl/serrx_pkg.sv
package serrx_pkg;

  // Master-to-frame ratio codes supplied by the ratio detector.
  typedef enum logic [1:0] {
    RATIO_256 = 2'd0,
    RATIO_384 = 2'd1,
    RATIO_512 = 2'd2,
    RATIO_BAD = 2'd3
  } ratio_e;

  // Strobes from the control to the datapath, one cycle each.
  typedef struct packed {
    logic capture;    // sample bitVal into the word under assembly
    logic bitVal;     // synchronized data bit
    logic closeWord;  // word ends after this cycle's capture
    logic closeRight; // closing word belongs to the right channel
    logic closeKeep;  // closing word is whole and may be used
    logic dropPair;   // forget any half-assembled pair
  } serrx_stb_t;

endpackage

// File: rtl/serrx_sync.sv
module serrx_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] dIn,
  output logic [W-1:0] dOut
);
  localparam int CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[CHAIN_W-W-1:0], dIn};
  end

  assign dOut = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/serrx_ctrl.sv
module serrx_ctrl
  import serrx_pkg::*;
#(
  parameter int BASE_DIV    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkIn,
  input  logic       lrclkIn,
  input  logic       sdataIn,
  input  logic [1:0] ratioCode,
  output serrx_stb_t stb,
  output logic       extMode,
  output logic       modeChg
);
  localparam int DIV_LONG = 2 * BASE_DIV;
  localparam int PH_W     = $clog2(DIV_LONG);
  localparam logic [PH_W-1:0] LAST_S = PH_W'(BASE_DIV - 1);
  localparam logic [PH_W-1:0] LAST_L = PH_W'(DIV_LONG - 1);
  localparam logic [PH_W-1:0] MID_S  = PH_W'(BASE_DIV / 2 - 1);
  localparam logic [PH_W-1:0] MID_L  = PH_W'(DIV_LONG / 2 - 1);

  ratio_e ratio;
  assign ratio = ratio_e'(ratioCode);

  // Synchronize the three serial pins together so data keeps its skew to the clocks.
  logic [2:0] syncBus;
  serrx_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rstN(rstN),
    .dIn ({sclkIn, lrclkIn, sdataIn}),
    .dOut(syncBus)
  );

  logic sclkS, lrS, sdS, sclkD, lrD;
  assign sclkS = syncBus[2];
  assign lrS   = syncBus[1];
  assign sdS   = syncBus[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkD <= 1'b0;
      lrD   <= 1'b0;
    end else begin
      sclkD <= sclkS;
      lrD   <= lrS;
    end
  end

  logic sclkRise, lrEdge, lrRise;
  assign sclkRise = sclkS & ~sclkD;
  assign lrEdge   = lrS ^ lrD;
  assign lrRise   = lrS & ~lrD;

  // Mode detection: one external edge enters, a quiet word-select period leaves.
  logic sawSclk;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extMode <= 1'b0;
      sawSclk <= 1'b0;
      modeChg <= 1'b0;
    end else begin
      modeChg <= 1'b0;
      if (!extMode) begin
        if (sclkRise) begin
          extMode <= 1'b1;
          modeChg <= 1'b1;
          sawSclk <= 1'b1;
        end
      end else if (lrRise) begin
        if (!sawSclk && !sclkRise) begin
          extMode <= 1'b0;
          modeChg <= 1'b1;
        end
        sawSclk <= sclkRise;
      end else if (sclkRise) begin
        sawSclk <= 1'b1;
      end
    end
  end

  // Internal bit strobe: divide the master clock, restarted on each word-select edge.
  logic [PH_W-1:0] phase, phaseLast, phaseMid;
  always_comb begin
    if (ratio == RATIO_512) begin
      phaseLast = LAST_L;
      phaseMid  = MID_L;
    end else begin
      phaseLast = LAST_S;
      phaseMid  = MID_S;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   phase <= '0;
    else if (lrEdge)             phase <= '0;
    else if (phase >= phaseLast) phase <= '0;
    else                         phase <= phase + 1'b1;
  end

  logic intRise, bitStb;
  assign intRise = (ratio != RATIO_BAD) && !lrEdge && (phase == phaseMid);
  assign bitStb  = extMode ? sclkRise : intRise;

  // Framing: the first strobe after a word-select edge is the slot that closes the old word.
  logic slotArmed, closeChan, wordOk;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotArmed <= 1'b0;
      closeChan <= 1'b0;
      wordOk    <= 1'b0;
    end else begin
      if (lrEdge) begin
        slotArmed <= 1'b1;
        closeChan <= lrD;
        if (slotArmed) wordOk <= 1'b0;
      end else if (stb.closeWord) begin
        slotArmed <= 1'b0;
        wordOk    <= 1'b1;
      end
      if (modeChg) wordOk <= 1'b0;
    end
  end

  always_comb begin
    stb            = '0;
    stb.bitVal     = sdS;
    stb.capture    = bitStb && !lrEdge;
    stb.closeWord  = bitStb && !lrEdge && slotArmed;
    stb.closeRight = closeChan;
    stb.closeKeep  = wordOk && !modeChg;
    stb.dropPair   = modeChg;
  end

  // R7: the mode pulse coincides with every flip of the mode flag and nothing else
  assert_modechg_flip_R7: assert property (@(posedge clk) disable iff (!rstN)
    modeChg == (extMode != $past(extMode)));

  // R5: an external edge seen in internal mode moves the block to external mode
  assert_ext_entry_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!extMode && sclkS && !sclkD) |=> extMode);

  // R8: an invalid ratio yields no internal bit strobes
  assert_bad_ratio_silent_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!extMode && ratioCode == 2'd3) |-> !stb.capture);

endmodule

// File: rtl/serrx_dpath.sv
module serrx_dpath
  import serrx_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  serrx_stb_t        stb,
  output logic [WORD_W-1:0] leftOut,
  output logic [WORD_W-1:0] rightOut,
  output logic              validOut
);
  localparam int PTR_W = $clog2(WORD_W + 1);
  localparam int IDX_W = $clog2(WORD_W);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(WORD_W);

  logic [WORD_W-1:0] word, wordNext, leftHold;
  logic [PTR_W-1:0]  ptr;
  logic [IDX_W-1:0]  wrIdx;
  logic              haveLeft, room;

  assign room  = ptr < PTR_MAX;
  assign wrIdx = IDX_W'(WORD_W - 1) - IDX_W'(ptr);

  // Bits land at a moving position from the top, so short words stay zero-padded.
  always_comb begin
    wordNext = word;
    if (stb.capture && room) wordNext[wrIdx] = stb.bitVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      word     <= '0;
      ptr      <= '0;
      leftHold <= '0;
      haveLeft <= 1'b0;
      leftOut  <= '0;
      rightOut <= '0;
      validOut <= 1'b0;
    end else begin
      validOut <= 1'b0;
      if (stb.closeWord) begin
        word <= '0;
        ptr  <= '0;
        if (stb.closeKeep) begin
          if (!stb.closeRight) begin
            leftHold <= wordNext;
            haveLeft <= 1'b1;
          end else if (haveLeft) begin
            leftOut  <= leftHold;
            rightOut <= wordNext;
            validOut <= 1'b1;
            haveLeft <= 1'b0;
          end
        end
      end else begin
        word <= wordNext;
        if (stb.capture && room) ptr <= ptr + 1'b1;
      end
      if (stb.dropPair) haveLeft <= 1'b0;
    end
  end

  // R2: one strobe per frame, never two cycles in a row
  assert_valid_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    validOut |=> !validOut);

  // R9: samples change only together with the strobe
  assert_hold_between_R9: assert property (@(posedge clk) disable iff (!rstN)
    (leftOut != $past(leftOut) || rightOut != $past(rightOut)) |-> validOut);

  // R4: a full word is frozen against extra bits until it closes
  assert_full_word_frozen_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ptr == PTR_MAX && !stb.closeWord) |=> $stable(word));

endmodule

// File: rtl/serrx_top.sv
module serrx_top
  import serrx_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int BASE_DIV    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              lrclkIn,
  input  logic              sdataIn,
  input  logic [1:0]        ratioCode,
  output logic [WORD_W-1:0] leftSample,
  output logic [WORD_W-1:0] rightSample,
  output logic              sampleValid,
  output logic              extClkMode,
  output logic              modeChange
);
  serrx_stb_t stb;

  serrx_ctrl #(.BASE_DIV(BASE_DIV), .SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclkIn   (sclkIn),
    .lrclkIn  (lrclkIn),
    .sdataIn  (sdataIn),
    .ratioCode(ratioCode),
    .stb      (stb),
    .extMode  (extClkMode),
    .modeChg  (modeChange)
  );

  serrx_dpath #(.WORD_W(WORD_W)) i_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .leftOut (leftSample),
    .rightOut(rightSample),
    .validOut(sampleValid)
  );
endmodule

// File: tb/test_serrx_top.sv
module test_serrx_top;
  localparam int WORD_W = 24;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, sclkIn, lrclkIn, sdataIn;
  logic [1:0] ratioCode;
  logic [WORD_W-1:0] leftSample, rightSample;
  logic sampleValid, extClkMode, modeChange;

  serrx_top i_serrx_top (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .lrclkIn(lrclkIn), .sdataIn(sdataIn),
    .ratioCode(ratioCode), .leftSample(leftSample), .rightSample(rightSample),
    .sampleValid(sampleValid), .extClkMode(extClkMode), .modeChange(modeChange)
  );

  int checksDone = 0, checksFailed = 0, chgCount = 0, validCount = 0;
  bit strict = 1'b1;
  string runTag = "R1 R2";
  logic [2*WORD_W-1:0] expQ[$];
  logic [WORD_W-1:0] lastL = '0, lastR = '0;
  logic [31:0] seed = 32'h1357_9bdf;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checksDone++;
    if (!ok) begin
      checksFailed++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] nextRand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  // Left-justified expectation: first WORD_W transmitted bits, zeros below.
  function automatic logic [WORD_W-1:0] expWord(input logic [31:0] w, input int bph);
    logic [WORD_W-1:0] e;
    e = '0;
    for (int i = 0; i < WORD_W; i++) e[WORD_W-1-i] = (i < bph) ? w[31-i] : 1'b0;
    return e;
  endfunction

  // Reference model: a queue of expected pairs, compared whenever a strobe appears.
  always @(negedge clk) begin
    if (rstN) begin
      if (modeChange) chgCount++;
      if (sampleValid) begin
        validCount++;
        if (strict) begin
          if (expQ.size() == 0) begin
            check(1'b0, runTag, "R2 unexpected strobe", 64'(leftSample), 64'd0);
          end else begin
            logic [2*WORD_W-1:0] e;
            e = expQ.pop_front();
            check(leftSample == e[2*WORD_W-1:WORD_W], runTag, "R1 R2 left word",
                  64'(leftSample), 64'(e[2*WORD_W-1:WORD_W]));
            check(rightSample == e[WORD_W-1:0], runTag, "R1 R2 right word",
                  64'(rightSample), 64'(e[WORD_W-1:0]));
            lastL = e[2*WORD_W-1:WORD_W];
            lastR = e[WORD_W-1:0];
          end
        end
      end
    end
  end

  // One word-select half: slot bit of the previous word, then the new word MSB first.
  task automatic sendHalf(input logic lvl, input logic [31:0] cur, input logic [31:0] prev,
                          input int bph, input bit ext, input int n);
    lrclkIn = lvl;
    for (int r = 1; r <= bph; r++) begin
      sdataIn = (r == 1) ? prev[32-bph] : cur[31-(r-2)];
      if (ext) begin
        repeat (4) @(negedge clk);
        sclkIn = 1'b1;
        repeat (4) @(negedge clk);
        sclkIn = 1'b0;
      end else begin
        repeat (n) @(negedge clk);
      end
    end
  endtask

  task automatic doReset(input logic [1:0] code);
    rstN = 1'b0; sclkIn = 1'b0; lrclkIn = 1'b0; sdataIn = 1'b0; ratioCode = code;
    repeat (4) @(negedge clk);
    expQ.delete();
    chgCount = 0; validCount = 0; strict = 1'b1;
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic runFrames(input bit ext, input logic [1:0] code, input int bph, input int n,
                           input int frames, input bit expectEmit, input string tag);
    logic [31:0] prev, cur, l, r;
    doReset(code);
    runTag = tag;
    prev = '0;
    cur = nextRand(); sendHalf(1'b0, cur, prev, bph, ext, n); prev = cur;
    cur = nextRand(); sendHalf(1'b1, cur, prev, bph, ext, n); prev = cur;
    for (int f = 0; f < frames; f++) begin
      l = nextRand(); r = nextRand();
      if (expectEmit) expQ.push_back({expWord(l, bph), expWord(r, bph)});
      sendHalf(1'b0, l, prev, bph, ext, n);
      sendHalf(1'b1, r, l, bph, ext, n);
      prev = r;
    end
    sendHalf(1'b0, nextRand(), prev, bph, ext, n);
    repeat (8) @(negedge clk);
    check(expQ.size() == 0, tag, "R2 all frames presented", 64'(expQ.size()), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checksDone++; checksFailed++;
    $display("FAIL watchdog R1 R2: actual=timeout expected=done");
    $display("%0d/%0d checks passed", checksDone - checksFailed, checksDone);
    $finish;
  end

  initial begin
    doReset(2'd0);
    check(leftSample == '0 && rightSample == '0, "R9", "reset samples",
          64'({leftSample, rightSample}), 64'd0);
    check(!sampleValid && !extClkMode && !modeChange, "R9", "reset flags",
          64'({sampleValid, extClkMode, modeChange}), 64'd0);

    runFrames(1'b0, 2'd0, 16, 8, 4, 1'b1, "R8 ratio256");
    check(extClkMode == 1'b0, "R8", "internal mode kept", 64'(extClkMode), 64'd0);
    check(chgCount == 0, "R7", "no mode pulse in internal run", 64'(chgCount), 64'd0);

    runFrames(1'b0, 2'd1, 24, 8, 4, 1'b1, "R8 ratio384");
    runFrames(1'b0, 2'd2, 16, 16, 3, 1'b1, "R8 ratio512");

    runFrames(1'b1, 2'd0, 32, 8, 4, 1'b1, "R4 ext32");
    check(extClkMode == 1'b1, "R5", "external mode entered", 64'(extClkMode), 64'd1);
    check(chgCount == 1, "R7", "one pulse on entry", 64'(chgCount), 64'd1);
    repeat (60) @(negedge clk);
    check(leftSample == lastL && rightSample == lastR, "R9", "samples held",
          64'({leftSample, rightSample}), 64'({lastL, lastR}));

    strict = 1'b0;
    sendHalf(1'b1, 32'd0, 32'd0, 16, 1'b0, 8);
    check(extClkMode == 1'b1, "R6", "still external after one rise", 64'(extClkMode), 64'd1);
    sendHalf(1'b0, 32'd0, 32'd0, 16, 1'b0, 8);
    sendHalf(1'b1, 32'd0, 32'd0, 16, 1'b0, 8);
    repeat (10) @(negedge clk);
    check(extClkMode == 1'b0, "R6", "back to internal after quiet period", 64'(extClkMode), 64'd0);
    check(chgCount == 2, "R7", "pulse on return", 64'(chgCount), 64'd2);

    runFrames(1'b1, 2'd0, 16, 8, 4, 1'b1, "R3 ext16");

    runFrames(1'b0, 2'd3, 16, 8, 3, 1'b0, "R8 invalid");
    check(validCount == 0, "R8", "no samples with invalid ratio", 64'(validCount), 64'd0);

    $display("%0d/%0d checks passed", checksDone - checksFailed, checksDone);
    $finish;
  end
endmodule